// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Router

This block sits between the per-core interrupt controllers of a multi-core cluster. It accepts one interrupt command at a time and works out which cores must receive it. A command comes either from one core's controller, with a source index, or from an external generator that has no source core. Each command carries a vector, a delivery mode, a physical/logical destination select, a shorthand code and an 8-bit destination field. The block reads every core's logical ID and addressing model to perform logical matching in both the flat and cluster styles. It also handles the self, all and all-but-self shorthands, and it checks physical IDs against the core count.

The result appears for one cycle as a per-core delivery strobe, with a shared vector and delivery kind. A per-core kick strobe marks fixed deliveries to cores other than the sender. An error flag covers illegal targets, unknown addressing models, unsupported delivery modes and unsupported combinations. When an error is flagged, nothing is delivered. A busy output blocks new commands while one is being evaluated.

Top module: `ipi_router`

## Requirements
- R1: A command is accepted on a rising edge where `cmd_valid` is 1 and `cmd_busy` is 0. `cmd_busy` is then 1 for exactly the next cycle, and commands presented during that cycle are ignored. The result strobes (`dlv_valid`, `kick`, `err`) are valid only in the cycle that follows the busy cycle, and they last one cycle.
- R2: Shorthand code 1 targets the source core only. Code 2 targets every core. Code 3 targets every core except the source, and targets every core when there is no source. Code 0 uses the destination field.
- R3: With shorthand 0 and `cmd_logical`=0, the destination field is a core index. A value greater than or equal to NUM_CORES sets `err` and delivers to no core.
- R4: With shorthand 0 and `cmd_logical`=1, a core whose model is 4'hF accepts when (its logical ID AND the destination) is nonzero.
- R5: Under the same conditions, a core whose model is 4'h0 accepts when the upper nibbles of its logical ID and of the destination are equal and the AND of their lower nibbles is nonzero.
- R6: A logical destination of 8'hFF is accepted by every core. In logical shorthand-0 addressing, any core with a model other than 4'hF or 4'h0 sets `err`.
- R7: Delivery modes 0 and 1 produce `dlv_kind`=0 (fixed). Mode 5 produces 1 (INIT) and mode 6 produces 2 (SIPI). Modes 2, 3, 4 and 7 set `err` when at least one core is targeted, and produce no output when no core is targeted.
- R8: Self shorthand with `cmd_logical`=1 and a source sets `err`. Self shorthand with `cmd_has_src`=0 is dropped with no delivery and no error.
- R9: A fixed delivery pulses `kick` for each targeted core other than the source. INIT and SIPI deliveries pulse no `kick`.
- R10: When `err` is set, no `dlv_valid` or `kick` bit is set. Otherwise, all targeted cores strobe in the same cycle, with `dlv_vector` equal to the command vector.
- R11: After reset, `cmd_busy`, `dlv_valid`, `kick` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_busy | output | 1 | Command under evaluation; new commands ignored |
| cmd_has_src | input | 1 | Command comes from a core (1) or an external generator (0) |
| cmd_src | input | CORE_W | Source core index |
| cmd_vector | input | 8 | Interrupt vector |
| cmd_mode | input | 3 | Delivery mode code |
| cmd_logical | input | 1 | 0 physical, 1 logical addressing |
| cmd_shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but source |
| cmd_dest | input | 8 | Destination field |
| tgt_ldr | input | 8*NUM_CORES | Logical ID of each core, core i at bits 8i+7:8i |
| tgt_model | input | 4*NUM_CORES | Addressing model of each core, core i at bits 4i+3:4i |
| dlv_valid | output | NUM_CORES | Per-core delivery strobe |
| dlv_vector | output | 8 | Vector of the delivery |
| dlv_kind | output | 2 | 0 fixed, 1 INIT, 2 SIPI |
| kick | output | NUM_CORES | Per-core strobe for remote fixed deliveries |
| err | output | 1 | Command rejected |

## Verification
Physical commands are tried with in-range and out-of-range indices, which tests the index decode against the range check. Logical commands are tried with both flat and cluster models. Their overlapping and disjoint masks show whether nibble comparison is used rather than a plain AND, and the broadcast value and an invalid model cover the overrides. The shorthands are tried with and without a source, which shows whether the sender is excluded or kicked. The delivery mode codes are tried both with targets present and with an empty target set, to show that the mode check depends on whether any core is targeted. A command presented during the busy cycle must leave no trace.

// File: rtl/ipi_router_pkg.sv
// Shared codes for the inter-processor interrupt router.
// Assumes 3-bit delivery mode codes and 2-bit shorthand codes.
package ipi_router_pkg;
    typedef enum logic [1:0] {
        KIND_FIXED = 2'd0,
        KIND_INIT  = 2'd1,
        KIND_SIPI  = 2'd2
    } dlv_kind_e;

    localparam logic [1:0] SH_NONE  = 2'd0;
    localparam logic [1:0] SH_SELF  = 2'd1;
    localparam logic [1:0] SH_ALL   = 2'd2;
    localparam logic [1:0] SH_OTHER = 2'd3;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;

    // Maps a mode code to a delivery kind; flags codes that are not carried.
    function automatic logic mode_supported(input logic [2:0] m);
        return (m == 3'd0) || (m == 3'd1) || (m == 3'd5) || (m == 3'd6);
    endfunction

    function automatic dlv_kind_e mode_kind(input logic [2:0] m);
        if (m == 3'd5) return KIND_INIT;
        if (m == 3'd6) return KIND_SIPI;
        return KIND_FIXED;
    endfunction
endpackage

// File: rtl/ipi_logical_match.sv
// Logical destination match for one core.
// Assumes the destination is an 8-bit mask; in the flat model it is a bit set,
// and in the cluster model it is a cluster number (upper nibble) plus a member set.
module ipi_logical_match
    import ipi_router_pkg::*;
(
    input  logic [7:0] dest,
    input  logic [7:0] ldr,
    input  logic [3:0] model,
    output logic       hit,
    output logic       bad_model
);
    // Decide acceptance under the core's addressing model.
    always_comb begin
        hit       = 1'b0;
        bad_model = 1'b0;
        if (model == MODEL_FLAT) begin
            hit = (dest == 8'hFF) || ((ldr & dest) != 8'h00);
        end else if (model == MODEL_CLUSTER) begin
            hit = (dest == 8'hFF) ||
                  ((ldr[7:4] == dest[7:4]) && ((ldr[3:0] & dest[3:0]) != 4'h0));
        end else begin
            bad_model = 1'b1;
        end
    end
endmodule

// File: rtl/ipi_target_select.sv
// Combinational target selection for a held command.
// Produces the set of targeted cores and one error flag; on error the set is empty.
// Assumes the command fields are stable for the evaluation cycle.
module ipi_target_select
    import ipi_router_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                   has_src,
    input  logic [CORE_W-1:0]      src,
    input  logic [2:0]             mode,
    input  logic                   logical,
    input  logic [1:0]             shorthand,
    input  logic [7:0]             dest,
    input  logic [8*NUM_CORES-1:0] ldr,
    input  logic [4*NUM_CORES-1:0] model,
    output logic [NUM_CORES-1:0]   sel,
    output logic [NUM_CORES-1:0]   src_mask,
    output logic                   error
);
    logic [NUM_CORES-1:0] log_hit;
    logic [NUM_CORES-1:0] log_bad;
    logic [NUM_CORES-1:0] phys_hit;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        ipi_logical_match u_match (
            .dest      (dest),
            .ldr       (ldr[8*i +: 8]),
            .model     (model[4*i +: 4]),
            .hit       (log_hit[i]),
            .bad_model (log_bad[i])
        );
        assign phys_hit[i] = (dest == 8'(i));
        assign src_mask[i] = has_src && (src == CORE_W'(i));
    end

    logic [NUM_CORES-1:0] raw_sel;
    logic                 raw_err;

    // Resolve the shorthand and addressing into a raw target set.
    always_comb begin
        raw_sel = '0;
        raw_err = 1'b0;
        case (shorthand)
            SH_NONE: begin
                if (!logical) begin
                    if (phys_hit == '0) raw_err = 1'b1;
                    else                raw_sel = phys_hit;
                end else begin
                    if (log_bad != '0) raw_err = 1'b1;
                    else               raw_sel = log_hit;
                end
            end
            SH_SELF: begin
                if (has_src) begin
                    if (logical) raw_err = 1'b1;
                    else         raw_sel = src_mask;
                end
            end
            SH_ALL:   raw_sel = '1;
            default:  raw_sel = ~src_mask;
        endcase
    end

    // Apply the mode check and suppress every target on error.
    always_comb begin
        error = raw_err || ((raw_sel != '0) && !mode_supported(mode));
        sel   = error ? '0 : raw_sel;
    end
endmodule

// File: rtl/ipi_router.sv
// Inter-processor interrupt destination router.
// Accepts one command, evaluates it for one cycle, then emits one-cycle
// per-core delivery and kick strobes or an error. Assumes the target
// logical IDs and models are stable while a command is busy.
module ipi_router
    import ipi_router_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_busy,
    input  logic                   cmd_has_src,
    input  logic [CORE_W-1:0]      cmd_src,
    input  logic [7:0]             cmd_vector,
    input  logic [2:0]             cmd_mode,
    input  logic                   cmd_logical,
    input  logic [1:0]             cmd_shorthand,
    input  logic [7:0]             cmd_dest,
    input  logic [8*NUM_CORES-1:0] tgt_ldr,
    input  logic [4*NUM_CORES-1:0] tgt_model,
    output logic [NUM_CORES-1:0]   dlv_valid,
    output logic [7:0]             dlv_vector,
    output logic [1:0]             dlv_kind,
    output logic [NUM_CORES-1:0]   kick,
    output logic                   err
);
    logic              h_has_src;
    logic [CORE_W-1:0] h_src;
    logic [7:0]        h_vector;
    logic [2:0]        h_mode;
    logic              h_logical;
    logic [1:0]        h_shorthand;
    logic [7:0]        h_dest;

    logic [NUM_CORES-1:0] sel;
    logic [NUM_CORES-1:0] src_mask;
    logic                 sel_err;
    dlv_kind_e            kind;

    // Hold the command while it is being evaluated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_busy    <= 1'b0;
            h_has_src   <= 1'b0;
            h_src       <= '0;
            h_vector    <= '0;
            h_mode      <= '0;
            h_logical   <= 1'b0;
            h_shorthand <= '0;
            h_dest      <= '0;
        end else if (cmd_busy) begin
            cmd_busy <= 1'b0;
        end else if (cmd_valid) begin
            cmd_busy    <= 1'b1;
            h_has_src   <= cmd_has_src;
            h_src       <= cmd_src;
            h_vector    <= cmd_vector;
            h_mode      <= cmd_mode;
            h_logical   <= cmd_logical;
            h_shorthand <= cmd_shorthand;
            h_dest      <= cmd_dest;
        end
    end

    ipi_target_select #(.NUM_CORES(NUM_CORES)) u_select (
        .has_src   (h_has_src),
        .src       (h_src),
        .mode      (h_mode),
        .logical   (h_logical),
        .shorthand (h_shorthand),
        .dest      (h_dest),
        .ldr       (tgt_ldr),
        .model     (tgt_model),
        .sel       (sel),
        .src_mask  (src_mask),
        .error     (sel_err)
    );

    // Delivery kind for the held mode.
    always_comb kind = mode_kind(h_mode);

    // Register the result strobes for exactly one cycle after evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid  <= '0;
            dlv_vector <= '0;
            dlv_kind   <= KIND_FIXED;
            kick       <= '0;
            err        <= 1'b0;
        end else if (cmd_busy) begin
            dlv_valid  <= sel;
            dlv_vector <= h_vector;
            dlv_kind   <= kind;
            kick       <= (kind == KIND_FIXED) ? (sel & ~src_mask) : '0;
            err        <= sel_err;
        end else begin
            dlv_valid <= '0;
            kick      <= '0;
            err       <= 1'b0;
        end
    end
endmodule

// File: rtl/ipi_router_checker.sv
// Protocol checks for the interrupt router, bound to every instance.
module ipi_router_checker
    import ipi_router_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_busy,
    input logic [NUM_CORES-1:0] dlv_valid,
    input logic [1:0]           dlv_kind,
    input logic [NUM_CORES-1:0] kick,
    input logic                 err
);
    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_busy) |=> cmd_busy);

    assert_busy_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> !cmd_busy);

    assert_result_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((dlv_valid != '0) || err) |-> $past(cmd_busy));

    assert_error_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ((dlv_valid == '0) && (kick == '0)));

    assert_kick_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((kick & ~dlv_valid) == '0));

    assert_kick_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kick != '0) |-> (dlv_kind == KIND_FIXED));
endmodule

bind ipi_router ipi_router_checker #(.NUM_CORES(NUM_CORES)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_busy  (cmd_busy),
    .dlv_valid (dlv_valid),
    .dlv_kind  (dlv_kind),
    .kick      (kick),
    .err       (err)
);

// File: tb/ipi_router_test.sv
// Directed bench for the interrupt router, four cores.
module ipi_router_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_busy;
    logic         cmd_has_src = 1'b0;
    logic [1:0]   cmd_src = '0;
    logic [7:0]   cmd_vector = '0;
    logic [2:0]   cmd_mode = '0;
    logic         cmd_logical = 1'b0;
    logic [1:0]   cmd_shorthand = '0;
    logic [7:0]   cmd_dest = '0;
    logic [8*N-1:0] tgt_ldr = 32'h0804_0201;
    logic [4*N-1:0] tgt_model = 16'hFFFF;
    logic [N-1:0] dlv_valid;
    logic [7:0]   dlv_vector;
    logic [1:0]   dlv_kind;
    logic [N-1:0] kick;
    logic         err;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ipi_router #(.NUM_CORES(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_busy(cmd_busy),
        .cmd_has_src(cmd_has_src), .cmd_src(cmd_src), .cmd_vector(cmd_vector),
        .cmd_mode(cmd_mode), .cmd_logical(cmd_logical), .cmd_shorthand(cmd_shorthand),
        .cmd_dest(cmd_dest), .tgt_ldr(tgt_ldr), .tgt_model(tgt_model),
        .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_kind(dlv_kind),
        .kick(kick), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one command and check busy, then the result cycle.
    task automatic send(input string req, input logic [1:0] sh, input logic lg,
                        input logic [2:0] md, input logic [7:0] dst, input logic [7:0] vec,
                        input logic hs, input logic [1:0] sr,
                        input logic [N-1:0] e_dlv, input logic [N-1:0] e_kick,
                        input logic e_err, input logic [1:0] e_kind);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_shorthand = sh; cmd_logical = lg; cmd_mode = md;
        cmd_dest = dst; cmd_vector = vec; cmd_has_src = hs; cmd_src = sr;
        @(negedge clk);
        cmd_valid = 1'b0;
        check({req, " busy R1"}, 32'(cmd_busy), 32'd1);
        @(negedge clk);
        check({req, " dlv"}, 32'(dlv_valid), 32'(e_dlv));
        check({req, " kick"}, 32'(kick), 32'(e_kick));
        check({req, " err"}, 32'(err), 32'(e_err));
        if (e_dlv != '0) begin
            check({req, " vector R10"}, 32'(dlv_vector), 32'(vec));
            check({req, " kind"}, 32'(dlv_kind), 32'(e_kind));
        end
    endtask

    task automatic test_reset();
        check("R11 busy", 32'(cmd_busy), 0);
        check("R11 dlv", 32'(dlv_valid), 0);
        check("R11 kick", 32'(kick), 0);
        check("R11 err", 32'(err), 0);
    endtask

    task automatic test_physical();
        send("R3 phys idx2", 2'd0, 0, 3'd0, 8'd2, 8'h41, 1, 2'd0, 4'b0100, 4'b0100, 0, 0);
        send("R3 phys idx4 out of range", 2'd0, 0, 3'd0, 8'd4, 8'h42, 1, 2'd0, 0, 0, 1, 0);
        send("R9 phys self-target no kick", 2'd0, 0, 3'd0, 8'd1, 8'h43, 1, 2'd1, 4'b0010, 4'b0000, 0, 0);
    endtask

    task automatic test_flat();
        send("R4 flat 0x06 lowest-prio R7", 2'd0, 1, 3'd1, 8'h06, 8'h50, 1, 2'd1, 4'b0110, 4'b0100, 0, 0);
        send("R6 flat broadcast", 2'd0, 1, 3'd0, 8'hFF, 8'h51, 0, 2'd0, 4'b1111, 4'b1111, 0, 0);
        send("R7 bad mode no target", 2'd0, 1, 3'd7, 8'h00, 8'h52, 0, 2'd0, 0, 0, 0, 0);
        send("R7 bad mode with target", 2'd0, 0, 3'd3, 8'd0, 8'h53, 0, 2'd0, 0, 0, 1, 0);
    endtask

    task automatic test_cluster();
        tgt_model = 16'h0000;
        tgt_ldr = 32'h2321_1211;
        send("R5 cluster 0x21", 2'd0, 1, 3'd0, 8'h21, 8'h60, 0, 2'd0, 4'b1100, 4'b1100, 0, 0);
        send("R5 cluster 0x12", 2'd0, 1, 3'd0, 8'h12, 8'h61, 0, 2'd0, 4'b0010, 4'b0010, 0, 0);
        send("R5 cluster 0x31 other cluster", 2'd0, 1, 3'd0, 8'h31, 8'h62, 0, 2'd0, 0, 0, 0, 0);
        send("R6 cluster broadcast", 2'd0, 1, 3'd0, 8'hFF, 8'h63, 0, 2'd0, 4'b1111, 4'b1111, 0, 0);
        tgt_model = 16'h5000;
        send("R6 invalid model", 2'd0, 1, 3'd0, 8'h21, 8'h64, 0, 2'd0, 0, 0, 1, 0);
        tgt_model = 16'hFFFF;
        tgt_ldr = 32'h0804_0201;
    endtask

    task automatic test_shorthand();
        send("R2 self phys", 2'd1, 0, 3'd0, 8'd0, 8'h70, 1, 2'd2, 4'b0100, 4'b0000, 0, 0);
        send("R8 self logical", 2'd1, 1, 3'd0, 8'd0, 8'h71, 1, 2'd2, 0, 0, 1, 0);
        send("R8 self no source", 2'd1, 0, 3'd0, 8'd0, 8'h72, 0, 2'd0, 0, 0, 0, 0);
        send("R2 all INIT R7", 2'd2, 0, 3'd5, 8'd0, 8'h73, 1, 2'd0, 4'b1111, 4'b0000, 0, 1);
        send("R2 all-but SIPI R7", 2'd3, 0, 3'd6, 8'd0, 8'h74, 1, 2'd1, 4'b1101, 4'b0000, 0, 2);
        send("R9 all-but no source", 2'd3, 0, 3'd0, 8'd0, 8'h75, 0, 2'd0, 4'b1111, 4'b1111, 0, 0);
    endtask

    // Command presented during the busy cycle must be ignored.
    task automatic test_busy_ignore();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_shorthand = 2'd0; cmd_logical = 1'b0; cmd_mode = 3'd0;
        cmd_dest = 8'd3; cmd_vector = 8'h80; cmd_has_src = 1'b0;
        @(negedge clk);
        cmd_dest = 8'd0; cmd_vector = 8'h81;
        check("R1 busy", 32'(cmd_busy), 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R1 first result", 32'(dlv_valid), 32'b1000);
        check("R1 first vector", 32'(dlv_vector), 32'h80);
        check("R1 not busy after result", 32'(cmd_busy), 0);
        @(negedge clk);
        check("R1 ignored cmd left no result", 32'(dlv_valid), 0);
        check("R1 still idle", 32'(cmd_busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_physical();
        test_flat();
        test_cluster();
        test_shorthand();
        test_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule